// File: doc/BRIEF.md
# Two-Level Page Walk Unit

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level page structure that sits in memory. A request carries the linear address, a user-mode flag and a write flag. The block also samples the directory base register and the write-protect enable when it accepts the request. It then makes two dependent word reads on a simple memory port. The first read fetches the directory entry and the second fetches the table entry. Each entry is checked for permission as soon as it arrives.

The walk ends with one result cycle. That cycle carries either the physical address or a fault. A fault reports a cause code, the level that faulted and the original linear address. Only one walk is in flight at a time. The memory port has no backpressure: every read request is a one-cycle strobe, and the response comes back any number of cycles later as a one-cycle valid.

Top module: `pageWalker`

## Requirements
- R1: The first read of a walk goes to `dirBase + 4 * linAddr[31:22]`.
- R2: The second read goes to the directory entry with bits 11:0 cleared, plus `4 * linAddr[21:12]`.
- R3: A walk with no fault returns `rspFault=0` and `rspPhys = {tableEntry[31:12], linAddr[11:0]}`. It makes exactly two reads.
- R4: If bit 0 (present) of an entry is 0, the walk faults with cause 0 (not present). This check runs before the other two.
- R5: If the request is user mode (`reqUser=1`) and bit 2 (user) of a present entry is 0, the walk faults with cause 1 (privilege). This check runs before the write check.
- R6: If the request is a write and bit 1 (writable) of the entry is 0, the walk faults with cause 2 (write). A user-mode write always faults in this case. A supervisor write faults only when `wpEnable` was 1 at acceptance.
- R7: A fault on the directory entry stops the walk. The result has `rspLevel=0` and no second read is made. A fault on the table entry reports `rspLevel=1`.
- R8: `reqReady` is low from the cycle after acceptance until the result cycle has passed. Every memory read is a single-cycle strobe.
- R9: A faulting result returns the accepted linear address unchanged on `rspAddr`.
- R10: After reset, `reqReady=1`, `rspValid=0` and `memReqValid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqAddr | input | 32 | Linear address to translate |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| reqWrite | input | 1 | 1 = write access |
| dirBase | input | 32 | Physical address of the page directory |
| wpEnable | input | 1 | Write protection also applies to supervisor writes |
| memReqValid | output | 1 | One-cycle word read strobe |
| memReqAddr | output | 32 | Read address |
| memRspValid | input | 1 | One-cycle read response valid |
| memRspData | input | 32 | Read data (page entry) |
| rspValid | output | 1 | One-cycle result strobe |
| rspFault | output | 1 | Result is a fault |
| rspCause | output | 2 | 0 not present, 1 privilege, 2 write |
| rspLevel | output | 1 | 0 directory entry, 1 table entry |
| rspPhys | output | 32 | Translated physical address |
| rspAddr | output | 32 | Linear address of the walk |

## Verification
The assertions assume the memory answers each read with exactly one `memRspValid` pulse. They also assume no response arrives unless a read is outstanding. The bench memory model keeps to this: it queues one response per observed strobe and delivers it after a latency of one to three cycles. It also holds `reqValid` only while the walker is idle. The sweep covers every combination of the three flag bits in both entries, together with the user, write and write-protect inputs. This gives 512 walks, and the bench compares each one with the permission and address rules it computes itself.

// File: rtl/walkPkg.sv
package walkPkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W = 10;
  localparam int OFF_W = 12;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE = 1;
  localparam int BIT_USER = 2;

  typedef enum logic [1:0] {
    CAUSE_ABSENT = 2'd0,
    CAUSE_PRIV   = 2'd1,
    CAUSE_WRITE  = 2'd2
  } causeT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PDE, ST_WAIT_PDE, ST_READ_PTE, ST_WAIT_PTE, ST_DONE
  } stateT;

  typedef struct packed {
    logic capture;
    logic issuePde;
    logic issuePte;
    logic takePde;
    logic takePte;
  } strobeT;

  typedef struct packed {
    logic  fault;
    causeT cause;
  } checkT;

  function automatic checkT checkEntry(logic [ADDR_W-1:0] entry, logic user,
                                       logic write, logic wp);
    checkT r;
    r.fault = 1'b1;
    r.cause = CAUSE_ABSENT;
    if (!entry[BIT_PRESENT]) r.cause = CAUSE_ABSENT;
    else if (user && !entry[BIT_USER]) r.cause = CAUSE_PRIV;
    else if (write && !entry[BIT_WRITE] && (user || wp)) r.cause = CAUSE_WRITE;
    else r.fault = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   memRspValid,
  input  logic   entryFault,
  output strobeT strobe,
  output logic   reqReady,
  output logic   memReqValid,
  output logic   rspValid
);
  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (reqValid) stateNext = ST_READ_PDE;
      ST_READ_PDE: stateNext = ST_WAIT_PDE;
      ST_WAIT_PDE: if (memRspValid) stateNext = entryFault ? ST_DONE : ST_READ_PTE;
      ST_READ_PTE: stateNext = ST_WAIT_PTE;
      ST_WAIT_PTE: if (memRspValid) stateNext = ST_DONE;
      ST_DONE:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && reqValid;
    strobe.issuePde = (state == ST_READ_PDE);
    strobe.issuePte = (state == ST_READ_PTE);
    strobe.takePde  = (state == ST_WAIT_PDE) && memRspValid;
    strobe.takePte  = (state == ST_WAIT_PTE) && memRspValid;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = strobe.issuePde || strobe.issuePte;
  assign rspValid    = (state == ST_DONE);
endmodule

// File: rtl/walkData.sv
module walkData
  import walkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              wpEnable,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              entryFault,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspFault,
  output logic [1:0]        rspCause,
  output logic              rspLevel,
  output logic [ADDR_W-1:0] rspPhys,
  output logic [ADDR_W-1:0] rspAddr
);
  logic [ADDR_W-1:0]  linAddr, baseReg;
  logic               userReg, writeReg, wpReg;
  logic [FRAME_W-1:0] tableFrame;
  logic [IDX_W-1:0]   dirIdx, tblIdx;
  logic [ADDR_W-1:0]  pdeAddr, pteAddr;
  checkT              chk;

  assign dirIdx = linAddr[ADDR_W-1 -: IDX_W];
  assign tblIdx = linAddr[OFF_W +: IDX_W];
  assign pdeAddr = baseReg + {{(ADDR_W-IDX_W-2){1'b0}}, dirIdx, 2'b00};
  assign pteAddr = {tableFrame, {OFF_W{1'b0}}} + {{(ADDR_W-IDX_W-2){1'b0}}, tblIdx, 2'b00};
  assign memReqAddr = strobe.issuePte ? pteAddr : pdeAddr;

  assign chk = checkEntry(memRspData, userReg, writeReg, wpReg);
  assign entryFault = chk.fault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linAddr    <= '0;
      baseReg    <= '0;
      userReg    <= 1'b0;
      writeReg   <= 1'b0;
      wpReg      <= 1'b0;
      tableFrame <= '0;
      rspFault   <= 1'b0;
      rspCause   <= 2'd0;
      rspLevel   <= 1'b0;
      rspPhys    <= '0;
    end else begin
      if (strobe.capture) begin
        linAddr  <= reqAddr;
        baseReg  <= dirBase;
        userReg  <= reqUser;
        writeReg <= reqWrite;
        wpReg    <= wpEnable;
      end
      if (strobe.takePde) begin
        tableFrame <= memRspData[ADDR_W-1:OFF_W];
        rspFault   <= chk.fault;
        rspCause   <= chk.cause;
        rspLevel   <= 1'b0;
      end
      if (strobe.takePte) begin
        rspFault <= chk.fault;
        rspCause <= chk.cause;
        rspLevel <= 1'b1;
        rspPhys  <= {memRspData[ADDR_W-1:OFF_W], linAddr[OFF_W-1:0]};
      end
    end
  end

  assign rspAddr = linAddr;
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqUser,
  input  logic        reqWrite,
  input  logic [31:0] dirBase,
  input  logic        wpEnable,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        rspValid,
  output logic        rspFault,
  output logic [1:0]  rspCause,
  output logic        rspLevel,
  output logic [31:0] rspPhys,
  output logic [31:0] rspAddr
);
  strobeT strobe;
  logic   entryFault;

  walkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .entryFault(entryFault), .strobe(strobe), .reqReady(reqReady),
    .memReqValid(memReqValid), .rspValid(rspValid)
  );

  walkData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqUser(reqUser), .reqWrite(reqWrite), .dirBase(dirBase),
    .wpEnable(wpEnable), .memRspData(memRspData), .entryFault(entryFault),
    .memReqAddr(memReqAddr), .rspFault(rspFault), .rspCause(rspCause),
    .rspLevel(rspLevel), .rspPhys(rspPhys), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/walkChecker.sv
module walkChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic [31:0] dirBase,
  input logic        memReqValid,
  input logic [31:0] memReqAddr,
  input logic        rspValid,
  input logic        rspFault,
  input logic [1:0]  rspCause,
  input logic        rspLevel,
  input logic [31:0] rspPhys,
  input logic [31:0] rspAddr
);
  logic [31:0] heldAddr, heldBase;
  logic [1:0]  readCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldBase <= '0;
      readCnt  <= 2'd0;
    end else if (reqValid && reqReady) begin
      heldAddr <= reqAddr;
      heldBase <= dirBase;
      readCnt  <= 2'd0;
    end else if (memReqValid && readCnt != 2'd3) begin
      readCnt <= readCnt + 2'd1;
    end
  end

  AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && readCnt == 2'd0) |-> memReqAddr == heldBase + {20'd0, heldAddr[31:22], 2'b00}); // R1
  AST_TWO_READS_OK: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (readCnt == 2'd2 && rspLevel)); // R3
  AST_PHYS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspPhys[11:0] == heldAddr[11:0]); // R3
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspCause != 2'd3); // R4
  AST_DIR_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault && !rspLevel) |-> readCnt == 2'd1); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady); // R8
  AST_READ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R8
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspAddr == heldAddr); // R9
endmodule

bind pageWalker walkChecker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .dirBase(dirBase), .memReqValid(memReqValid),
  .memReqAddr(memReqAddr), .rspValid(rspValid), .rspFault(rspFault),
  .rspCause(rspCause), .rspLevel(rspLevel), .rspPhys(rspPhys), .rspAddr(rspAddr)
);

// File: tb/sim_pageWalker.sv
`timescale 1ns/1ps
module sim_pageWalker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqUser = 1'b0, reqWrite = 1'b0, wpEnable = 1'b0;
  logic [31:0] reqAddr = '0, dirBase = '0;
  logic reqReady, memReqValid, memRspValid = 1'b0;
  logic [31:0] memReqAddr, memRspData = '0;
  logic rspValid, rspFault, rspLevel;
  logic [1:0] rspCause;
  logic [31:0] rspPhys, rspAddr;

  int checks = 0, fails = 0;
  bit finished = 0;
  localparam logic [31:0] BASE = 32'h0001_2000;

  always #2.5 clk = ~clk;

  pageWalker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqUser(reqUser), .reqWrite(reqWrite), .dirBase(dirBase),
    .wpEnable(wpEnable), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspFault(rspFault), .rspCause(rspCause), .rspLevel(rspLevel),
    .rspPhys(rspPhys), .rspAddr(rspAddr)
  );

  // Bench memory image: directory entry flags = dir index bits 2:0, table frame {0x100, dir};
  // table entry flags = table index bits 2:0, physical frame {2'b10, dir, tbl[7:0]}.
  function automatic logic [31:0] memWord(logic [31:0] a);
    if (a[31:12] == BASE[31:12])
      return {10'h100, a[11:2], 9'd0, a[4:2]};
    else if (a[31:22] == 10'h100)
      return {2'b10, a[21:12], a[9:2], 9'd0, a[4:2]};
    else
      return 32'd0;
  endfunction

  // Bench permission rule: 0 ok, else cause+1
  function automatic int permOf(logic [2:0] fl, logic u, logic w, logic wp);
    if (!fl[0]) return 1;
    if (u && !fl[2]) return 2;
    if (w && !fl[1] && (u || wp)) return 3;
    return 0;
  endfunction

  int readCount = 0;
  logic [31:0] readAddr [0:3];
  bit pending = 0;
  int countDown = 0, latency = 1;
  logic [31:0] pendAddr = '0;

  always @(negedge clk) begin
    memRspValid <= 1'b0;
    if (pending) begin
      if (countDown == 1) begin
        memRspValid <= 1'b1;
        memRspData  <= memWord(pendAddr);
        pending = 0;
      end else countDown = countDown - 1;
    end
    if (memReqValid) begin
      if (readCount < 4) readAddr[readCount] = memReqAddr;
      readCount = readCount + 1;
      pending = 1;
      pendAddr = memReqAddr;
      countDown = latency;
      latency = (latency % 3) + 1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic walk(logic [9:0] d, logic [9:0] t, logic [11:0] off,
                      logic u, logic w, logic wp);
    logic [31:0] la, expPhys;
    int p1, p2, expCause, expLevel, expReads, waitCnt;
    bit expFault;
    la = {d, t, off};
    p1 = permOf(d[2:0], u, w, wp);
    p2 = permOf(t[2:0], u, w, wp);
    expFault = (p1 != 0) || (p2 != 0);
    expLevel = (p1 != 0) ? 0 : 1;
    expCause = (p1 != 0) ? p1 - 1 : p2 - 1;
    expReads = (p1 != 0) ? 1 : 2;
    expPhys = {2'b10, d, t[7:0], off};
    readCount = 0;
    @(negedge clk);
    reqValid = 1; reqAddr = la; reqUser = u; reqWrite = w; wpEnable = wp; dirBase = BASE;
    @(negedge clk);
    reqValid = 0; wpEnable = ~wp; dirBase = 32'hFFFF_0000;
    check(!reqReady, "R8 ready low after accept", {31'd0, reqReady}, 32'd0);
    waitCnt = 0;
    while (!rspValid && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
      if (!rspValid) check(!reqReady, "R8 ready low while busy", {31'd0, reqReady}, 32'd0);
    end
    check(rspValid, "R8 result arrives", {31'd0, rspValid}, 32'd1);
    check(readCount == expReads, "R7 read count", readCount, expReads);
    check(readAddr[0] == BASE + {20'd0, d, 2'b00}, "R1 directory read address",
          readAddr[0], BASE + {20'd0, d, 2'b00});
    if (p1 == 0)
      check(readAddr[1] == {10'h100, d, 12'd0} + {20'd0, t, 2'b00}, "R2 table read address",
            readAddr[1], {10'h100, d, 12'd0} + {20'd0, t, 2'b00});
    check(rspFault == expFault, "R4 R5 R6 fault flag", {31'd0, rspFault}, {31'd0, expFault});
    if (expFault) begin
      if (expCause == 0) check(rspCause == 2'd0, "R4 not-present cause", rspCause, 0);
      else if (expCause == 1) check(rspCause == 2'd1, "R5 privilege cause", rspCause, 1);
      else check(rspCause == 2'd2, "R6 write cause", rspCause, 2);
      check(rspLevel == expLevel[0], "R7 fault level", {31'd0, rspLevel}, expLevel);
      check(rspAddr == la, "R9 fault address", rspAddr, la);
    end else begin
      check(rspPhys == expPhys, "R3 physical address", rspPhys, expPhys);
    end
    @(negedge clk);
    check(reqReady && !rspValid, "R8 idle after result", {30'd0, reqReady, rspValid}, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R10 reset state",
          {29'd0, reqReady, rspValid, memReqValid}, 32'd4);
    rstN = 1;
    @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R10 idle after reset",
          {29'd0, reqReady, rspValid, memReqValid}, 32'd4);
    for (int d = 0; d < 8; d++)
      for (int t = 0; t < 8; t++)
        for (int m = 0; m < 8; m++) begin
          logic [9:0] di, ti;
          logic [11:0] of;
          di = 10'(d * 129);
          ti = 10'(t * 65 + m * 8);
          of = 12'(d * 37 + t * 91 + m * 511);
          walk(di, ti, of, m[0], m[1], m[2]);
        end
    finish();
  end
endmodule